// File: doc/BRIEF.md
# Crypto DMA Interrupt and Error-Status Controller

This block drives the two interrupt lines of a DMA-fed crypto accelerator and holds its sticky error status. It watches the operation start strobe (with a flag telling whether the operation uses DMA), the idle levels of the DMA engine and of the crypto core, an input-transfer-finished strobe, and error strobes from the bus and the key store. It raises a result flag when a DMA-based operation completes, and an input-done flag when the input transfer of such an operation ends. Operations that run without DMA never raise either flag.

Software reaches the block through a small register port with four write targets: a type register, a per-source enable register, a write-one-to-clear register and a write-one-to-set register for test. The five status bits are always visible on a read-only output. Each interrupt line is gated by the global enable and by its own source enable. It is either a level that follows its flag or a one-cycle pulse when the flag rises.

Top module: `crypto_irq_ctrl`

## Requirements
- R1: After reset all five status bits are 0 and both interrupt outputs are low.
- R2: An interrupt output can be high only while the global enable (type register, address 0, bit 0) is 1 and its source enable (address 1; bit 0 result, bit 1 input-done) is 1.
- R3: A start strobe with the DMA flag set arms tracking. The result flag (status bit 0) is set on the first following cycle in which both the DMA and the core idle inputs are 1, and it is set only once per armed operation.
- R4: The input-done flag (status bit 1) is set by the input-done strobe only while a DMA operation is armed.
- R5: A start strobe without the DMA flag disarms tracking, and neither flag is raised by that operation.
- R6: Writing address 2 clears every status bit whose write-data bit is 1 (bit 0 result, 1 input-done, 2 bus error, 3 key-write error, 4 key-read error).
- R7: Writing address 3 sets the flags whose write-data bits 0 and 1 are 1.
- R8: The bus-error (bit 2) and key-write-error (bit 3) bits latch on their strobe and stay set until cleared.
- R9: The key-read-error bit (bit 4) latches on its strobe only after a key-load request. That pending request is consumed by the error it reports.
- R10: With the type register bit 1 at 0 an enabled interrupt is a level equal to its flag. With bit 1 at 1 it is high for exactly one cycle after the flag rises.
- R11: When a clear and a new event hit the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Operation start strobe |
| op_uses_dma | input | 1 | Qualifies op_start: the operation uses DMA |
| dma_idle | input | 1 | DMA engine idle level |
| core_idle | input | 1 | Crypto core idle level |
| in_dma_done | input | 1 | Input DMA transfer finished strobe |
| err_bus | input | 1 | Bus error strobe |
| err_key_wr | input | 1 | Key-store write error strobe |
| err_key_rd | input | 1 | Key-store read error strobe |
| key_load_req | input | 1 | Key-load request strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 type, 1 enable, 2 clear, 3 set |
| reg_wdata | input | 5 | Register write data |
| status | output | 5 | Status flags and error bits |
| irq_result | output | 1 | Result-available interrupt |
| irq_dma_in | output | 1 | Input-done interrupt |

## Verification
The hardest case to reach is a completion event and a software clear that land on the same status bit in the same cycle. The bench arms a DMA operation while both idle levels are low. In one cycle it then raises both idle levels and writes the clear register, and expects the result flag to remain set. It also reaches the pulse output only through the set register with pulse mode active, then checks that the line falls one cycle later while the flag stays high.

// File: rtl/crypto_irq_ctrl.sv
module crypto_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start,
  input  logic       op_uses_dma,
  input  logic       dma_idle,
  input  logic       core_idle,
  input  logic       in_dma_done,
  input  logic       err_bus,
  input  logic       err_key_wr,
  input  logic       err_key_rd,
  input  logic       key_load_req,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [4:0] reg_wdata,
  output logic [4:0] status,
  output logic       irq_result,
  output logic       irq_dma_in
);

  logic       glob_en, pulse_mode;
  logic [1:0] src_en;
  logic       armed, kl_pend;
  logic [4:0] stat_q;
  logic [1:0] flag_d;

  wire wr_type = reg_wr && reg_addr == 2'd0;
  wire wr_en   = reg_wr && reg_addr == 2'd1;
  wire wr_clr  = reg_wr && reg_addr == 2'd2;
  wire wr_set  = reg_wr && reg_addr == 2'd3;

  wire [4:0] clr_mask = wr_clr ? reg_wdata : 5'd0;
  wire [1:0] set_mask = wr_set ? reg_wdata[1:0] : 2'd0;

  wire res_evt = armed & dma_idle & core_idle;
  wire din_evt = armed & in_dma_done;
  wire krd_evt = kl_pend & err_key_rd;

  wire [4:0] evt = {krd_evt, err_key_wr, err_bus, din_evt | set_mask[1], res_evt | set_mask[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_en    <= 1'b0;
      pulse_mode <= 1'b0;
      src_en     <= 2'd0;
      armed      <= 1'b0;
      kl_pend    <= 1'b0;
      stat_q     <= 5'd0;
      flag_d     <= 2'd0;
    end else begin
      if (wr_type) begin
        glob_en    <= reg_wdata[0];
        pulse_mode <= reg_wdata[1];
      end
      if (wr_en) src_en <= reg_wdata[1:0];
      if (op_start)     armed <= op_uses_dma;
      else if (res_evt) armed <= 1'b0;
      if (key_load_req)    kl_pend <= 1'b1;
      else if (err_key_rd) kl_pend <= 1'b0;
      stat_q <= (stat_q & ~clr_mask) | evt;
      flag_d <= stat_q[1:0];
    end
  end

  wire [1:0] live = pulse_mode ? (stat_q[1:0] & ~flag_d) : stat_q[1:0];
  wire [1:0] irq  = live & src_en & {2{glob_en}};

  assign status     = stat_q;
  assign irq_result = irq[0];
  assign irq_dma_in = irq[1];

endmodule

module crypto_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       armed,
  input logic       dma_idle,
  input logic       core_idle,
  input logic       glob_en,
  input logic       pulse_mode,
  input logic [1:0] src_en,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [4:0] reg_wdata,
  input logic       err_bus,
  input logic [4:0] status,
  input logic       irq_result,
  input logic       irq_dma_in
);

  assert_irq_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_result |-> glob_en && src_en[0]) and (irq_dma_in |-> glob_en && src_en[1]));

  assert_result_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> $past(armed && dma_idle && core_idle) ||
                         $past(reg_wr && reg_addr == 2'd3 && reg_wdata[0]));

  assert_bus_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] && !(reg_wr && reg_addr == 2'd2 && reg_wdata[2]) |=> status[2]);

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_result && pulse_mode && !(reg_wr && reg_addr == 2'd0) |=> !irq_result);

  assert_event_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_bus |=> status[2]);

endmodule

bind crypto_irq_ctrl crypto_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .armed(armed), .dma_idle(dma_idle), .core_idle(core_idle),
  .glob_en(glob_en), .pulse_mode(pulse_mode), .src_en(src_en), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .err_bus(err_bus), .status(status),
  .irq_result(irq_result), .irq_dma_in(irq_dma_in)
);

// File: tb/crypto_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module crypto_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic op_start = 0, op_uses_dma = 0, dma_idle = 0, core_idle = 0, in_dma_done = 0;
  logic err_bus = 0, err_key_wr = 0, err_key_rd = 0, key_load_req = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [4:0] reg_wdata = 0;
  logic [4:0] status;
  logic irq_result, irq_dma_in;

  always #2 clk = ~clk;

  crypto_irq_ctrl dut_i (.*);

  typedef struct { string req; logic [4:0] st; logic res; logic din; } exp_t;
  exp_t q[$];
  event push_ev;
  int checks = 0, errors = 0;
  bit done = 0;

  task automatic tick();
    @(posedge clk); @(negedge clk);
    op_start = 0; in_dma_done = 0; err_bus = 0; err_key_wr = 0;
    err_key_rd = 0; key_load_req = 0; reg_wr = 0;
  endtask

  task automatic expect_out(string req, logic [4:0] st, logic res, logic din);
    exp_t e;
    e.req = req; e.st = st; e.res = res; e.din = din;
    q.push_back(e);
    -> push_ev;
    #0.5;
  endtask

  task automatic wreg(logic [1:0] a, logic [4:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  initial begin
    forever begin
      @(push_ev);
      #0.2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (status !== e.st || irq_result !== e.res || irq_dma_in !== e.din) begin
          errors++;
          $display("FAIL %s: got st=%b res=%b din=%b exp st=%b res=%b din=%b",
                   e.req, status, irq_result, irq_dma_in, e.st, e.res, e.din);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    expect_out("R1", 5'b00000, 0, 0);
    rst_n = 1; tick();
    expect_out("R1", 5'b00000, 0, 0);
    wreg(2'd0, 5'b00001);
    wreg(2'd1, 5'b00011);
    expect_out("R2", 5'b00000, 0, 0);
    // non-DMA operation
    dma_idle = 1; core_idle = 1;
    op_start = 1; op_uses_dma = 0; tick(); tick();
    expect_out("R5", 5'b00000, 0, 0);
    in_dma_done = 1; tick();
    expect_out("R4", 5'b00000, 0, 0);
    // DMA operation
    dma_idle = 0; core_idle = 0;
    op_start = 1; op_uses_dma = 1; tick(); tick();
    expect_out("R3", 5'b00000, 0, 0);
    in_dma_done = 1; tick();
    expect_out("R4", 5'b00010, 0, 1);
    dma_idle = 1; tick();
    expect_out("R3", 5'b00010, 0, 1);
    core_idle = 1; tick();
    expect_out("R3", 5'b00011, 1, 1);
    wreg(2'd2, 5'b00011);
    expect_out("R6", 5'b00000, 0, 0);
    tick(); tick();
    expect_out("R3", 5'b00000, 0, 0);
    // global enable and set
    wreg(2'd0, 5'b00000);
    wreg(2'd3, 5'b00001);
    expect_out("R7", 5'b00001, 0, 0);
    wreg(2'd0, 5'b00001);
    expect_out("R2", 5'b00001, 1, 0);
    wreg(2'd1, 5'b00010);
    expect_out("R2", 5'b00001, 0, 0);
    wreg(2'd3, 5'b00010);
    expect_out("R7", 5'b00011, 0, 1);
    wreg(2'd2, 5'b00011);
    wreg(2'd1, 5'b00011);
    expect_out("R6", 5'b00000, 0, 0);
    // errors
    err_bus = 1; tick();
    expect_out("R8", 5'b00100, 0, 0);
    tick(); tick();
    expect_out("R8", 5'b00100, 0, 0);
    err_key_wr = 1; tick(); tick();
    expect_out("R8", 5'b01100, 0, 0);
    err_key_rd = 1; tick();
    expect_out("R9", 5'b01100, 0, 0);
    key_load_req = 1; tick();
    err_key_rd = 1; tick();
    expect_out("R9", 5'b11100, 0, 0);
    wreg(2'd2, 5'b11100);
    expect_out("R6", 5'b00000, 0, 0);
    // pulse mode
    wreg(2'd0, 5'b00011);
    wreg(2'd3, 5'b00001);
    expect_out("R10", 5'b00001, 1, 0);
    tick();
    expect_out("R10", 5'b00001, 0, 0);
    tick();
    expect_out("R10", 5'b00001, 0, 0);
    wreg(2'd2, 5'b00001);
    wreg(2'd0, 5'b00001);
    // clear and event in same cycle
    dma_idle = 0; core_idle = 0;
    op_start = 1; op_uses_dma = 1; tick();
    dma_idle = 1; core_idle = 1;
    reg_wr = 1; reg_addr = 2'd2; reg_wdata = 5'b00001; tick();
    expect_out("R11", 5'b00001, 1, 0);
    err_bus = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = 5'b00100; tick();
    expect_out("R11", 5'b00101, 1, 0);
    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule